// File: doc/BRIEF.md
# Pipelined Zero-Turnaround Synchronous SRAM

This block is a synthesizable behavioural model of a pipelined synchronous static RAM. It takes one command on every rising clock edge. Reads and writes may follow each other in any order with no idle cycle between them. Each command owns one data slot on a shared three-state bus. That slot is the clock period that ends at the second rising edge after the command was sampled. A read drives its word into that period. A write expects its word to be on the bus during that period. Because every command keeps this same fixed distance to its data, the bus carries useful data in every cycle.

A command either loads a fresh start address or advances a four-beat burst from the last loaded address. An advance beat reuses the stored read or write direction. The burst order is interleaved or linear, chosen by a strap input. Byte lanes of nine bits each have their own active-low write enable, so a write can update only some lanes. Three chip enables must all be active before a command is accepted, which lets several devices share a bus in a deeper memory. A sleep input blocks new commands but keeps the array and the burst state. The output enable releases the bus at once, without waiting for a clock edge.

Top module: `zt_sram`

## Requirements
- R1: A read command sampled at edge E puts the addressed word on `dq` after edge E+1. The word stays on the bus until edge E+2. When no read owns that slot, the block does not drive `dq`.
- R2: For a write command sampled at edge E, the block captures its data from `dq` at edge E+2.
- R3: Reads and writes may be issued on consecutive edges in any mix. A read issued on the edge right after a write to the same address returns the newly written lanes, and the other lanes keep their stored value.
- R4: `bwe_n[i]` low on a write beat writes lane i, which is `dq[9*i+8:9*i]`. Lanes with `bwe_n[i]` high keep their stored contents.
- R5: A command is accepted only when `ce_a_n`=0, `ce_b`=1 and `ce_c_n`=0. In any other case the cycle performs no operation: no array change and no bus drive in its slot.
- R6: When `adv`=0, the block loads `addr` as the burst start and takes the direction from `we_n` (0 = write, 1 = read). When `adv`=1, it issues the next beat of the stored burst in the stored direction, and `addr` and `we_n` are ignored.
- R7: When `burst_lin`=0, beat k of a burst uses the start address with its low two bits XORed with k.
- R8: When `burst_lin`=1, beat k uses the low two bits of the start address plus k, modulo 4. In both orders the upper address bits stay at the start value.
- R9: The beat count wraps after four beats, so the fifth beat of a burst returns to the start address.
- R10: With `oe_n`=1, `dq` is released at once, even during a read slot.
- R11: While `sleep`=1, commands (loads and advances) are ignored. The array and the burst counter keep their state, and operation resumes when `sleep` returns to 0.
- R12: After reset, no operation is pending and `dq` is released. An advance issued with no earlier load reads a burst starting at address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all registers update on the rising edge |
| rst | input | 1 | Synchronous active-high reset of the pipeline and burst state |
| addr | input | ADDR_W | Word address taken on a load |
| adv | input | 1 | 1 = advance current burst, 0 = load new start address |
| we_n | input | 1 | Direction on a load: 0 write, 1 read |
| ce_a_n | input | 1 | Chip enable, active low |
| ce_b | input | 1 | Chip enable, active high |
| ce_c_n | input | 1 | Chip enable, active low |
| bwe_n | input | LANES | Per-lane write enables, active low, taken with each command |
| oe_n | input | 1 | Asynchronous output enable, active low |
| burst_lin | input | 1 | Burst order: 0 interleaved, 1 linear |
| sleep | input | 1 | 1 = ignore commands, keep state |
| dq | inout | LANES*LANE_W | Shared three-state data bus |

## Verification
The assertions assume that reset is held for at least one edge before the first command. They also assume that the bus is driven by someone else only in write slots. The stimulus follows both rules. Each command is paired in the bench with its data slot two edges later. The bench drives `dq` only in the slot of a write it has issued. During every other slot it leaves the bus to a weak pull-up, so an undriven bus reads as all ones. Read data patterns always contain zero bits, so an undriven bus can never be mistaken for a valid read.

// File: rtl/zt_sram_pkg.sv
package zt_sram_pkg;

    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_RD   = 2'd1,
        OP_WR   = 2'd2
    } op_e;

    // Low two address bits of a burst beat
    function automatic logic [1:0] beat_low(input logic [1:0] start,
                                            input logic [1:0] cnt,
                                            input logic       lin);
        logic [1:0] r;
        if (lin) r = start + cnt;
        else     r = start ^ cnt;
        return r;
    endfunction

endpackage

// File: rtl/zt_burst_ctr.sv
module zt_burst_ctr #(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              issue,
    input  logic              load,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              wr_in,
    input  logic              lin,
    output logic [ADDR_W-1:0] beat_addr,
    output logic              beat_wr
);
    import zt_sram_pkg::*;

    logic [ADDR_W-1:0] base_q;
    logic [1:0]        cnt_q;
    logic              wr_q;
    logic [1:0]        cnt_nxt;

    assign cnt_nxt = cnt_q + 2'd1;

    always_comb begin
        if (load) begin
            beat_addr = addr_in;
            beat_wr   = wr_in;
        end else begin
            beat_addr = {base_q[ADDR_W-1:2], beat_low(base_q[1:0], cnt_nxt, lin)};
            beat_wr   = wr_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            cnt_q  <= '0;
            wr_q   <= 1'b0;
        end else if (issue) begin
            if (load) begin
                base_q <= addr_in;
                cnt_q  <= '0;
                wr_q   <= wr_in;
            end else begin
                cnt_q  <= cnt_nxt;
            end
        end
    end

endmodule

// File: rtl/zt_cmd_pipe.sv
module zt_cmd_pipe #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  zt_sram_pkg::op_e         op_in,
    input  logic [ADDR_W-1:0]        a_in,
    input  logic [LANES-1:0]         be_in,
    output zt_sram_pkg::op_e         s1_op,
    output logic [ADDR_W-1:0]        s1_a,
    output zt_sram_pkg::op_e         s2_op,
    output logic [ADDR_W-1:0]        s2_a,
    output logic [LANES-1:0]         s2_be
);
    import zt_sram_pkg::*;

    typedef struct packed {
        op_e               op;
        logic [ADDR_W-1:0] a;
        logic [LANES-1:0]  be;
    } stage_t;

    localparam int STAGES = 2;

    stage_t st_q [STAGES];
    stage_t st_in;

    assign st_in = '{op: op_in, a: a_in, be: be_in};

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) begin
                st_q[s] <= '{op: OP_NONE, a: '0, be: '0};
            end else begin
                st_q[s] <= (s == 0) ? st_in : st_q[(s == 0) ? 0 : s - 1];
            end
        end
    end

    assign s1_op = st_q[0].op;
    assign s1_a  = st_q[0].a;
    assign s2_op = st_q[1].op;
    assign s2_a  = st_q[1].a;
    assign s2_be = st_q[1].be;

endmodule

// File: rtl/zt_array.sv
module zt_array #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 2,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       wr_a,
    input  logic [LANES-1:0]        wr_be,
    input  logic [LANES*LANE_W-1:0] wr_d,
    input  logic                    rd_en,
    input  logic [ADDR_W-1:0]       rd_a,
    output logic [LANES*LANE_W-1:0] rd_q,
    output logic                    rd_vld
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int W     = LANES * LANE_W;

    logic [W-1:0] rd_word;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [LANE_W-1:0] lane_mem [DEPTH];
        logic              hit;

        always_ff @(posedge clk) begin
            if (wr_en && wr_be[i]) begin
                lane_mem[wr_a] <= wr_d[i*LANE_W +: LANE_W];
            end
        end

        // write landing on this edge forwards its lane to a read of the same word
        assign hit = wr_en && wr_be[i] && (wr_a == rd_a);
        assign rd_word[i*LANE_W +: LANE_W] = hit ? wr_d[i*LANE_W +: LANE_W]
                                                 : lane_mem[rd_a];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_vld <= 1'b0;
            rd_q   <= '0;
        end else begin
            rd_vld <= rd_en;
            if (rd_en) begin
                rd_q <= rd_word;
            end
        end
    end

endmodule

// File: rtl/zt_sram.sv
module zt_sram #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 2,
    parameter int LANE_W = 9
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [ADDR_W-1:0]         addr,
    input  logic                      adv,
    input  logic                      we_n,
    input  logic                      ce_a_n,
    input  logic                      ce_b,
    input  logic                      ce_c_n,
    input  logic [LANES-1:0]          bwe_n,
    input  logic                      oe_n,
    input  logic                      burst_lin,
    input  logic                      sleep,
    inout  wire  [LANES*LANE_W-1:0]   dq
);
    import zt_sram_pkg::*;

    localparam int W = LANES * LANE_W;

    logic              sel;
    logic              issue;
    logic [ADDR_W-1:0] beat_addr;
    logic              beat_wr;
    op_e               op_in;
    op_e               s1_op;
    op_e               s2_op;
    logic [ADDR_W-1:0] s1_a;
    logic [ADDR_W-1:0] s2_a;
    logic [LANES-1:0]  s2_be;
    logic [W-1:0]      rd_q;
    logic              rd_vld;

    assign sel   = !ce_a_n && ce_b && !ce_c_n;
    assign issue = sel && !sleep;

    zt_burst_ctr #(.ADDR_W(ADDR_W)) burst_i (
        .clk       (clk),
        .rst       (rst),
        .issue     (issue),
        .load      (!adv),
        .addr_in   (addr),
        .wr_in     (!we_n),
        .lin       (burst_lin),
        .beat_addr (beat_addr),
        .beat_wr   (beat_wr)
    );

    always_comb begin
        if (!issue)       op_in = OP_NONE;
        else if (beat_wr) op_in = OP_WR;
        else              op_in = OP_RD;
    end

    zt_cmd_pipe #(.ADDR_W(ADDR_W), .LANES(LANES)) pipe_i (
        .clk   (clk),
        .rst   (rst),
        .op_in (op_in),
        .a_in  (beat_addr),
        .be_in (~bwe_n),
        .s1_op (s1_op),
        .s1_a  (s1_a),
        .s2_op (s2_op),
        .s2_a  (s2_a),
        .s2_be (s2_be)
    );

    zt_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) array_i (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (s2_op == OP_WR),
        .wr_a   (s2_a),
        .wr_be  (s2_be),
        .wr_d   (dq),
        .rd_en  (s1_op == OP_RD),
        .rd_a   (s1_a),
        .rd_q   (rd_q),
        .rd_vld (rd_vld)
    );

    assign dq = (rd_vld && !oe_n) ? rd_q : {W{1'bz}};

endmodule

// File: rtl/zt_sram_chk.sv
module zt_sram_chk #(
    parameter int ADDR_W = 6
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  sel,
    input logic                  issue,
    input logic                  sleep,
    input logic                  adv,
    input logic [ADDR_W-1:0]     addr,
    input zt_sram_pkg::op_e      s1_op,
    input logic [ADDR_W-1:0]     s1_a,
    input logic                  rd_vld
);
    import zt_sram_pkg::*;

    // R11
    sleep_block_chk: assert property (@(posedge clk) disable iff (rst)
        sleep |=> s1_op == OP_NONE);

    // R5
    desel_block_chk: assert property (@(posedge clk) disable iff (rst)
        !sel |=> s1_op == OP_NONE);

    // R1
    rd_slot_chk: assert property (@(posedge clk) disable iff (rst)
        s1_op == OP_RD |=> rd_vld);

    // R1
    rd_src_chk: assert property (@(posedge clk) disable iff (rst)
        rd_vld |-> $past(s1_op) == OP_RD);

    // R6
    load_addr_chk: assert property (@(posedge clk) disable iff (rst)
        (issue && !adv) |=> s1_a == $past(addr));

endmodule

bind zt_sram zt_sram_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk    (clk),
    .rst    (rst),
    .sel    (sel),
    .issue  (issue),
    .sleep  (sleep),
    .adv    (adv),
    .addr   (addr),
    .s1_op  (s1_op),
    .s1_a   (s1_a),
    .rd_vld (rd_vld)
);

// File: tb/zt_sram_tb.sv
module zt_sram_tb_top;

    localparam int CLK_P = 10;
    localparam int AW    = 6;
    localparam int NB    = 2;
    localparam int LW    = 9;
    localparam int W     = NB * LW;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] addr = '0;
    logic          adv = 1'b0;
    logic          we_n = 1'b1;
    logic          ce_a_n = 1'b1;
    logic          ce_b = 1'b0;
    logic          ce_c_n = 1'b1;
    logic [NB-1:0] bwe_n = '1;
    logic          oe_n = 1'b0;
    logic          burst_lin = 1'b0;
    logic          sleep = 1'b0;
    wire  [W-1:0]  dq;

    logic          drv_en = 1'b0;
    logic [W-1:0]  drv_d = '0;

    assign dq = drv_en ? drv_d : {W{1'bz}};
    for (genvar i = 0; i < W; i++) begin : g_pu
        pullup pu (dq[i]);
    end

    always #(CLK_P/2) clk = ~clk;

    zt_sram #(.ADDR_W(AW), .LANES(NB), .LANE_W(LW)) dut_i (
        .clk(clk), .rst(rst), .addr(addr), .adv(adv), .we_n(we_n),
        .ce_a_n(ce_a_n), .ce_b(ce_b), .ce_c_n(ce_c_n), .bwe_n(bwe_n),
        .oe_n(oe_n), .burst_lin(burst_lin), .sleep(sleep), .dq(dq)
    );

    int n_cmp = 0;
    int n_bad = 0;

    logic [W-1:0] ref_mem [DEPTH];
    logic [AW-1:0] rb_base = '0;
    logic [1:0]    rb_cnt  = '0;
    logic          rb_wr   = 1'b0;

    // two-deep record of issued commands: kind 0 none, 1 read, 2 write
    int            pk [2];
    logic [AW-1:0] pa [2];
    logic [NB-1:0] pbe [2];
    logic [W-1:0]  pwd [2];
    logic          poe [2];
    string         preq [2];

    function automatic logic [W-1:0] pat(input int a, input int salt);
        int v;
        v = (a * 37 + salt * 101 + 5) ^ (a << 9);
        return W'(v) & ~W'(18'h20001 << (a % 8));
    endfunction

    task automatic chk(input logic [W-1:0] got, input logic [W-1:0] exp, input string req);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s actual %h expected %h", req, got, exp);
        end
    endtask

    // one command per call; csm 0 = selected, 1..3 = one enable inactive
    task automatic step(input int csm, input logic adv_i, input logic we_i,
                        input logic [AW-1:0] a_i, input logic [NB-1:0] bwn_i,
                        input logic slp_i, input logic [W-1:0] wd_i,
                        input logic oen_i, input string req);
        logic          iss;
        logic [AW-1:0] eff;
        logic [1:0]    lo;
        // data slot of the command issued two calls ago
        oe_n = poe[1];
        if (pk[1] == 2) begin
            drv_en = 1'b1;
            drv_d  = pwd[1];
            for (int l = 0; l < NB; l++)
                if (pbe[1][l]) ref_mem[pa[1]][l*LW +: LW] = pwd[1][l*LW +: LW];
        end else begin
            drv_en = 1'b0;
        end
        #1;
        if (pk[1] == 1)      chk(dq, poe[1] ? {W{1'b1}} : ref_mem[pa[1]], preq[1]);
        else if (pk[1] == 0) chk(dq, {W{1'b1}}, preq[1]);
        // bench model of the burst counter and command acceptance
        iss = (csm == 0) && !slp_i;
        eff = a_i;
        if (iss) begin
            if (!adv_i) begin
                rb_base = a_i; rb_cnt = 2'd0; rb_wr = !we_i;
            end else begin
                rb_cnt = rb_cnt + 2'd1;
                lo  = burst_lin ? 2'(rb_base[1:0] + rb_cnt) : (rb_base[1:0] ^ rb_cnt);
                eff = {rb_base[AW-1:2], lo};
            end
        end
        pk[1] = pk[0]; pa[1] = pa[0]; pbe[1] = pbe[0]; pwd[1] = pwd[0];
        poe[1] = poe[0]; preq[1] = preq[0];
        pk[0]  = !iss ? 0 : (rb_wr ? 2 : 1);
        pa[0]  = eff; pbe[0] = ~bwn_i; pwd[0] = wd_i; poe[0] = oen_i; preq[0] = req;
        ce_a_n = (csm == 1); ce_b = (csm != 2); ce_c_n = (csm == 3);
        adv = adv_i; we_n = we_i; addr = a_i; bwe_n = bwn_i; sleep = slp_i;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle(input string req);
        step(1, 1'b0, 1'b1, '0, '1, 1'b0, '0, 1'b0, req);
    endtask

    task automatic wr1(input int a, input logic [W-1:0] d, input logic [NB-1:0] bwn, input string req);
        step(0, 1'b0, 1'b0, AW'(a), bwn, 1'b0, d, 1'b0, req);
    endtask

    task automatic rd1(input int a, input logic oen, input string req);
        step(0, 1'b0, 1'b1, AW'(a), '1, 1'b0, '0, oen, req);
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual running expected finished");
        finish_run();
    end

    initial begin
        for (int k = 0; k < 2; k++) begin
            pk[k] = 0; pa[k] = '0; pbe[k] = '0; pwd[k] = '0; poe[k] = 1'b0; preq[k] = "R12";
        end
        for (int a = 0; a < DEPTH; a++) ref_mem[a] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R12: released bus after reset
        idle("R12"); idle("R12");

        // R2 fill, R1 read-back
        for (int a = 0; a < DEPTH; a++) wr1(a, pat(a, 1), '0, "R2");
        for (int a = 0; a < DEPTH; a++) rd1(a, 1'b0, "R1");
        idle("R1"); idle("R1");

        // R3 alternating write/read of the same word
        for (int a = 0; a < DEPTH; a++) begin
            wr1(a, pat(a, 2), '0, "R3");
            rd1(a, 1'b0, "R3");
        end
        idle("R3"); idle("R3");

        // R4 every lane mask, read straight after and later
        for (int a = 0; a < 16; a++) begin
            wr1(a, pat(a, 3), NB'(a), "R4");
            rd1(a, 1'b0, "R4");
        end
        for (int a = 0; a < 16; a++) rd1(a, 1'b0, "R4");
        idle("R4"); idle("R4");

        // R6 R7 R8 R9 bursts in both orders from every start offset
        for (int lin = 0; lin < 2; lin++) begin
            for (int s = 0; s < 4; s++) begin
                int base;
                base = (8 + s + 4 * lin) * 4 + s;
                burst_lin = lin[0];
                step(0, 1'b0, 1'b1, AW'(base), '1, 1'b0, '0, 1'b0, lin ? "R8" : "R7");
                for (int b = 1; b <= 5; b++)
                    step(0, 1'b1, 1'b0, AW'(63 - b), '0, 1'b0, '0, 1'b0,
                         (b >= 4) ? "R9" : "R6");
                step(0, 1'b0, 1'b0, AW'(base), '0, 1'b0, pat(base, 4), 1'b0, "R6");
                for (int b = 1; b < 4; b++)
                    step(0, 1'b1, 1'b1, AW'(b), '0, 1'b0, pat(base + b, 4), 1'b0, "R6");
                step(0, 1'b0, 1'b1, AW'(base), '1, 1'b0, '0, 1'b0, lin ? "R8" : "R7");
                for (int b = 1; b < 4; b++)
                    step(0, 1'b1, 1'b1, AW'(0), '1, 1'b0, '0, 1'b0, lin ? "R8" : "R7");
            end
        end
        burst_lin = 1'b0;
        idle("R6"); idle("R6");

        // R5 each enable inactive: write dropped, read not driven
        for (int m = 1; m < 4; m++) begin
            step(m, 1'b0, 1'b0, AW'(5), '0, 1'b0, pat(m, 9), 1'b0, "R5");
            idle("R5");
            rd1(5, 1'b0, "R5");
            step(m, 1'b0, 1'b1, AW'(5), '1, 1'b0, '0, 1'b0, "R5");
        end
        idle("R5"); idle("R5");

        // R11 sleep drops a write and holds the burst count
        step(0, 1'b0, 1'b0, AW'(6), '0, 1'b1, pat(6, 11), 1'b0, "R11");
        idle("R11");
        rd1(6, 1'b0, "R11");
        step(0, 1'b0, 1'b1, AW'(40), '1, 1'b0, '0, 1'b0, "R11");
        step(0, 1'b1, 1'b1, AW'(0), '1, 1'b0, '0, 1'b0, "R11");
        step(0, 1'b1, 1'b1, AW'(0), '1, 1'b1, '0, 1'b0, "R11");
        step(0, 1'b1, 1'b1, AW'(0), '1, 1'b0, '0, 1'b0, "R11");
        step(0, 1'b1, 1'b1, AW'(0), '1, 1'b0, '0, 1'b0, "R11");
        idle("R11"); idle("R11");

        // R10 output enable high releases a read slot
        rd1(7, 1'b1, "R10");
        rd1(7, 1'b0, "R10");
        rd1(8, 1'b1, "R10");
        idle("R10"); idle("R10");

        finish_run();
    end

endmodule